// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block keeps a small direct-mapped write-back cache coherent with its peers on a shared bus. It holds a tag and a coherence state for every line. Each state is one of three: not present, present read-only with possible copies elsewhere, or held exclusively and dirty. The block reacts to two event streams. The first is local processor reads and writes. The second is bus transactions issued by other caches, which it snoops. From these it decides when to issue a bus read, when to ask for ownership (a request that invalidates every other copy), when a dirty victim must be written back, and when it must drive the line's data onto the bus itself instead of memory.

Every event is settled in a single clock. Bus grant, memory timing and data storage sit outside the block. All outputs are registered and appear on the clock edge after the request. A cache that has won ownership keeps writing locally, and those writes never reach the bus. A peer that later reads the line gets the data from this cache, not from memory.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: While reset is held and just after it, every line is invalid and bus_valid_o, wb_valid_o and supply_o are 0. The first access to any address is therefore a miss.
- R2: A local read (cpu_write_i=0) that misses issues a bus read one clock later: bus_valid_o=1, bus_op_o=0, bus_addr_o equal to the request address. The line becomes shared, so a repeat read of that address causes no bus request.
- R3: A local write (cpu_write_i=1) to a line that is invalid or shared issues an ownership request one clock later (bus_op_o=1, bus_addr_o equal to the request address). The line becomes exclusive.
- R4: A local write to a line already held exclusive completes without any bus request.
- R5: A snooped read (snp_op_i=0) that hits a line held exclusive raises supply_o one clock later and leaves the line shared. A later local write then needs an ownership request.
- R6: A snooped ownership request (snp_op_i=1) that hits a held line makes it invalid. supply_o is raised one clock later only if the line was exclusive.
- R7: A snooped invalidation (snp_op_i=2) that hits a held line makes it invalid and never raises supply_o.
- R8: A snoop whose address does not hit a valid line (tag differs or line invalid) changes no state and raises no supply. Snoop code 3 is ignored.
- R9: A miss whose victim line holds a different tag in the exclusive state raises wb_valid_o together with the new bus request, with wb_addr_o carrying the victim's address. A shared or invalid victim causes no write-back.
- R10: When a snoop and a local request hit the same line in one clock, the snoop takes effect first. The local request then acts on the state the snoop left.
- R11: A snooped read that hits a shared line leaves it shared and raises no supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Local request present this clock |
| cpu_write_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Line address of the local request |
| snp_valid_i | input | 1 | Snooped transaction present this clock |
| snp_op_i | input | 2 | 0 read, 1 ownership, 2 invalidate, 3 none |
| snp_addr_i | input | ADDR_W | Line address of the snooped transaction |
| bus_valid_o | output | 1 | Bus request issued |
| bus_op_o | output | 1 | 0 read, 1 ownership |
| bus_addr_o | output | ADDR_W | Address of the bus request |
| wb_valid_o | output | 1 | Dirty victim must be written back |
| wb_addr_o | output | ADDR_W | Address of the victim line |
| supply_o | output | 1 | This cache supplies the snooped line's data |

## Verification
The properties take it for granted that each bus request is granted in the clock it appears. They also take it that every input is a one-clock pulse that is known whenever reset is released. Under those conditions a bus request or a write-back can only follow a local request, and a supply can only follow a snoop. The stimulus drives at most one local request and one snoop per clock, using a small pool of addresses that share indexes, so hits, conflicts and same-line collisions happen often. It also sends combinations a real bus would not produce, such as an invalidation aimed at an exclusive line. For those the requirements still define the result, and the reference model in the bench follows them.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    SNP_RD  = 2'd0,
    SNP_OWN = 2'd1,
    SNP_INV = 2'd2,
    SNP_NOP = 2'd3
  } snp_op_e;

  typedef enum logic {
    BUS_RD  = 1'b0,
    BUS_OWN = 1'b1
  } bus_op_e;
endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ra_idx_i,
  output line_st_e         ra_st_o,
  output logic [TAG_W-1:0] ra_tag_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output line_st_e         rb_st_o,
  output logic [TAG_W-1:0] rb_tag_o,
  input  logic             ua_en_i,
  input  logic [IDX_W-1:0] ua_idx_i,
  input  line_st_e         ua_st_i,
  input  logic [TAG_W-1:0] ua_tag_i,
  input  logic             ub_en_i,
  input  logic [IDX_W-1:0] ub_idx_i,
  input  line_st_e         ub_st_i
);
  localparam int LINES = 1 << IDX_W;

  line_st_e         st_arr  [LINES];
  logic [TAG_W-1:0] tag_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e         st_q;
    logic [TAG_W-1:0] tag_q;

    // port a (local side) already folds in the snoop result, so it wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= LN_INV;
        tag_q <= '0;
      end else if (ua_en_i && ua_idx_i == IDX_W'(g)) begin
        st_q  <= ua_st_i;
        tag_q <= ua_tag_i;
      end else if (ub_en_i && ub_idx_i == IDX_W'(g)) begin
        st_q  <= ub_st_i;
      end
    end

    assign st_arr[g]  = st_q;
    assign tag_arr[g] = tag_q;
  end

  assign ra_st_o  = st_arr[ra_idx_i];
  assign ra_tag_o = tag_arr[ra_idx_i];
  assign rb_st_o  = st_arr[rb_idx_i];
  assign rb_tag_o = tag_arr[rb_idx_i];
endmodule

// File: rtl/coh_snoop_rules.sv
module coh_snoop_rules
  import coh_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic             valid_i,
  input  snp_op_e          op_i,
  input  logic [TAG_W-1:0] tag_i,
  input  line_st_e         st_i,
  input  logic [TAG_W-1:0] held_tag_i,
  output logic             we_o,
  output line_st_e         nst_o,
  output logic             supply_o
);
  logic match;

  always_comb begin
    match    = valid_i && (st_i != LN_INV) && (held_tag_i == tag_i);
    we_o     = 1'b0;
    nst_o    = st_i;
    supply_o = 1'b0;
    if (match) begin
      unique case (op_i)
        SNP_RD: begin
          if (st_i == LN_EXC) begin
            we_o     = 1'b1;
            nst_o    = LN_SHR;
            supply_o = 1'b1;
          end
        end
        SNP_OWN: begin
          we_o     = 1'b1;
          nst_o    = LN_INV;
          supply_o = (st_i == LN_EXC);
        end
        SNP_INV: begin
          we_o  = 1'b1;
          nst_o = LN_INV;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_cpu_rules.sv
module coh_cpu_rules
  import coh_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [TAG_W-1:0] tag_i,
  input  line_st_e         st_i,
  input  logic [TAG_W-1:0] held_tag_i,
  output logic             we_o,
  output line_st_e         nst_o,
  output logic             bus_o,
  output bus_op_e          op_o,
  output logic             evict_o
);
  logic hit;
  logic dirty_victim;

  always_comb begin
    hit          = (st_i != LN_INV) && (held_tag_i == tag_i);
    dirty_victim = (st_i == LN_EXC) && (held_tag_i != tag_i);
    we_o         = 1'b0;
    nst_o        = st_i;
    bus_o        = 1'b0;
    op_o         = BUS_RD;
    evict_o      = 1'b0;
    if (req_i) begin
      if (wr_i) begin
        if (!(hit && st_i == LN_EXC)) begin
          we_o    = 1'b1;
          nst_o   = LN_EXC;
          bus_o   = 1'b1;
          op_o    = BUS_OWN;
          evict_o = dirty_victim;
        end
      end else if (!hit) begin
        we_o    = 1'b1;
        nst_o   = LN_SHR;
        bus_o   = 1'b1;
        op_o    = BUS_RD;
        evict_o = dirty_victim;
      end
    end
  end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_write_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              bus_valid_o,
  output logic              bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic              supply_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  line_st_e         a_st, b_st, snp_nst, cpu_nst, eff_st;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic             snp_we, snp_sup, cpu_we, cpu_bus, cpu_evict;
  bus_op_e          cpu_op;
  logic             same_line;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  coh_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_idx_i (cpu_idx),
    .ra_st_o  (a_st),
    .ra_tag_o (a_tag),
    .rb_idx_i (snp_idx),
    .rb_st_o  (b_st),
    .rb_tag_o (b_tag),
    .ua_en_i  (cpu_we),
    .ua_idx_i (cpu_idx),
    .ua_st_i  (cpu_nst),
    .ua_tag_i (cpu_tag),
    .ub_en_i  (snp_we),
    .ub_idx_i (snp_idx),
    .ub_st_i  (snp_nst)
  );

  coh_snoop_rules #(.TAG_W(TAG_W)) u_snoop (
    .valid_i    (snp_valid_i),
    .op_i       (snp_op_e'(snp_op_i)),
    .tag_i      (snp_tag),
    .st_i       (b_st),
    .held_tag_i (b_tag),
    .we_o       (snp_we),
    .nst_o      (snp_nst),
    .supply_o   (snp_sup)
  );

  // snoop first: local side sees the post-snoop state of a shared index
  assign same_line = snp_we && (snp_idx == cpu_idx);
  assign eff_st    = same_line ? snp_nst : a_st;

  coh_cpu_rules #(.TAG_W(TAG_W)) u_cpu (
    .req_i      (cpu_valid_i),
    .wr_i       (cpu_write_i),
    .tag_i      (cpu_tag),
    .st_i       (eff_st),
    .held_tag_i (a_tag),
    .we_o       (cpu_we),
    .nst_o      (cpu_nst),
    .bus_o      (cpu_bus),
    .op_o       (cpu_op),
    .evict_o    (cpu_evict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_valid_o <= 1'b0;
      bus_op_o    <= 1'b0;
      bus_addr_o  <= '0;
      wb_valid_o  <= 1'b0;
      wb_addr_o   <= '0;
      supply_o    <= 1'b0;
    end else begin
      bus_valid_o <= cpu_bus;
      wb_valid_o  <= cpu_evict;
      supply_o    <= snp_sup;
      if (cpu_bus) begin
        bus_op_o   <= cpu_op;
        bus_addr_o <= cpu_addr_i;
      end
      if (cpu_evict) wb_addr_o <= {a_tag, cpu_idx};
    end
  end
endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_valid_i,
  input logic              cpu_write_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              snp_valid_i,
  input logic [1:0]        snp_op_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              bus_valid_o,
  input logic              bus_op_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              wb_valid_o,
  input logic [ADDR_W-1:0] wb_addr_o,
  input logic              supply_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!bus_valid_o && !wb_valid_o && !supply_o);
    end
  end

  // R2
  bus_from_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> $past(cpu_valid_i) && bus_addr_o == $past(cpu_addr_i));

  // R2
  read_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_op_o) |-> !$past(cpu_write_i));

  // R3
  own_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_op_o) |-> $past(cpu_write_i));

  // R9
  wb_with_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> bus_valid_o && wb_addr_o != bus_addr_o);

  // R8
  supply_needs_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snp_valid_i || snp_op_i[1]) |=> !supply_o);
endmodule

bind snoop_coh_ctrl coh_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/snoop_coh_ctrl_test.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_test;
  localparam int AW = 10;
  localparam int IW = 3;
  localparam int TW = AW - IW;
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_op = 2'd3;
  logic [AW-1:0] snp_addr = '0;
  logic          bus_valid, bus_op, wb_valid, supply;
  logic [AW-1:0] bus_addr, wb_addr;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  snoop_coh_ctrl #(.ADDR_W(AW), .IDX_W(IW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_write_i(cpu_write), .cpu_addr_i(cpu_addr),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_addr_i(snp_addr),
    .bus_valid_o(bus_valid), .bus_op_o(bus_op), .bus_addr_o(bus_addr),
    .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .supply_o(supply)
  );

  // reference model: 0 invalid, 1 shared, 2 exclusive
  logic [1:0]    m_st  [NL];
  logic [TW-1:0] m_tag [NL];
  logic          e_bv, e_op, e_wb, e_sup, pend;
  logic [AW-1:0] e_ba, e_wa;
  string         e_req;

  task automatic model(input logic cv, cw, input logic [AW-1:0] ca,
                       input logic sv, input logic [1:0] so, input logic [AW-1:0] sa);
    logic [IW-1:0] si, ci;
    logic [TW-1:0] st, ct;
    logic hit;
    si = sa[IW-1:0]; st = sa[AW-1:IW];
    ci = ca[IW-1:0]; ct = ca[AW-1:IW];
    e_bv = 0; e_op = 0; e_wb = 0; e_sup = 0; e_ba = '0; e_wa = '0;
    if (sv && m_st[si] != 2'd0 && m_tag[si] == st) begin
      case (so)
        2'd0: if (m_st[si] == 2'd2) begin e_sup = 1; m_st[si] = 2'd1; end
        2'd1: begin e_sup = (m_st[si] == 2'd2); m_st[si] = 2'd0; end
        2'd2: m_st[si] = 2'd0;
        default: ;
      endcase
    end
    hit = (m_st[ci] != 2'd0) && (m_tag[ci] == ct);
    if (cv) begin
      if (cw ? !(hit && m_st[ci] == 2'd2) : !hit) begin
        e_bv = 1; e_op = cw; e_ba = ca;
        if (m_st[ci] == 2'd2 && m_tag[ci] != ct) begin
          e_wb = 1; e_wa = {m_tag[ci], ci};
        end
        m_st[ci] = cw ? 2'd2 : 2'd1;
        m_tag[ci] = ct;
      end
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      tests++;
      if (bus_valid !== e_bv || supply !== e_sup || wb_valid !== e_wb ||
          (e_bv && (bus_op !== e_op || bus_addr !== e_ba)) ||
          (e_wb && wb_addr !== e_wa)) begin
        fails++;
        $display("FAIL %s: got bv=%0d op=%0d a=%h wb=%0d wa=%h sup=%0d exp bv=%0d op=%0d a=%h wb=%0d wa=%h sup=%0d",
                 e_req, bus_valid, bus_op, bus_addr, wb_valid, wb_addr, supply,
                 e_bv, e_op, e_ba, e_wb, e_wa, e_sup);
      end
      pend = 0;
    end
  endtask

  task automatic step(input logic cv, cw, input logic [AW-1:0] ca,
                      input logic sv, input logic [1:0] so, input logic [AW-1:0] sa,
                      input string rq);
    @(negedge clk);
    check_pending();
    cpu_valid = cv; cpu_write = cw; cpu_addr = ca;
    snp_valid = sv; snp_op = so; snp_addr = sa;
    model(cv, cw, ca, sv, so, sa);
    e_req = rq;
    pend = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string rq); step(1, 0, a, 0, 2'd3, '0, rq); endtask
  task automatic wr(input logic [AW-1:0] a, input string rq); step(1, 1, a, 0, 2'd3, '0, rq); endtask
  task automatic sn(input logic [1:0] o, input logic [AW-1:0] a, input string rq); step(0, 0, '0, 1, o, a, rq); endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang exp finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    pend = 0;
    for (int i = 0; i < NL; i++) begin m_st[i] = 2'd0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset
    tests++;
    if (bus_valid !== 0 || wb_valid !== 0 || supply !== 0) begin
      fails++;
      $display("FAIL R1: got bv=%0d wb=%0d sup=%0d exp 0 0 0", bus_valid, wb_valid, supply);
    end
    rst_n = 1'b1;
    rd(10'h011, "R1 first access misses, R2 bus read");
    rd(10'h011, "R2 read hit no bus");
    wr(10'h011, "R3 ownership from shared");
    wr(10'h011, "R4 write exclusive silent");
    sn(2'd0, 10'h011, "R5 supply on snoop read");
    wr(10'h011, "R5 line left shared needs ownership");
    sn(2'd0, 10'h011, "R5 supply again");
    sn(2'd0, 10'h011, "R11 snoop read shared no supply");
    wr(10'h011, "R11 still shared then ownership");
    sn(2'd2, 10'h011, "R7 invalidate no supply");
    rd(10'h011, "R7 line invalid after invalidate");
    wr(10'h011, "R3 ownership");
    sn(2'd1, 10'h011, "R6 ownership transfer supplies");
    rd(10'h011, "R6 line invalid after transfer");
    sn(2'd1, 10'h011, "R6 shared line no supply");
    rd(10'h011, "R6 invalid again");
    sn(2'd1, 10'h019, "R8 tag mismatch ignored");
    sn(2'd3, 10'h011, "R8 code 3 ignored");
    rd(10'h011, "R8 line still shared");
    sn(2'd0, 10'h055, "R8 invalid line no supply");
    wr(10'h011, "R3 take ownership");
    rd(10'h021, "R9 dirty victim written back");
    rd(10'h031, "R9 shared victim no writeback");
    step(1, 0, 10'h031, 1, 2'd1, 10'h031, "R10 snoop first then read misses");
    wr(10'h042, "R3 ownership 042");
    step(1, 1, 10'h042, 1, 2'd0, 10'h042, "R10 supply then ownership");
    wr(10'h022, "R9 write miss evicts dirty 042");
    void'($urandom(32'h0000_5eed));
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a, b;
      a = {5'd0, 2'($urandom_range(3)), 1'b0, 2'($urandom_range(3))};
      b = ($urandom_range(3) == 0) ? a : {5'd0, 2'($urandom_range(3)), 1'b0, 2'($urandom_range(3))};
      step(1'($urandom_range(1)), 1'($urandom_range(1)), a,
           1'($urandom_range(1)), 2'($urandom_range(3)), b,
           (a == b) ? "R10 random" : "R2 R3 R5 R6 R9 random");
    end
    step(0, 0, '0, 0, 2'd3, '0, "idle");
    @(negedge clk);
    check_pending();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule